// File: doc/BRIEF.md
# Local Bus Peripheral Cycle Controller

This block sits between a synchronous local bus and a slow asynchronous peripheral that has chip-select, read and write strobes. It also serves a small bank of general-purpose I/O: output latches that the bus can write, and input buffers that it can read. An active-low address strobe sampled in idle opens a cycle. On that edge the block latches the address, the direction and the first write word. It also loads a wait-state count taken from a configuration input.

While the cycle runs, the block holds the strobes of exactly one target steady, chosen by one address bit. When the count reaches zero it raises ready for one clock. The edge that ends that clock captures read data, or updates the output latches on a GPIO write. If the active-low burst-last input is low on that edge, the strobes are released. If it is high, a further data phase follows with the next word address.

Every access, to the peripheral or to the GPIO bank, lasts the programmed count plus one clock per data phase. A slow device therefore sees a known access time. The clock and reset come from the surrounding logic.

Top module: `lbc_cycle_ctrl`

## Requirements
- R1: While reset is applied and after it is released, every strobe is inactive, `lb_ready` is 0, `per_addr`, `per_wdata` and `lb_rdata` are 0, and `gpio_out` holds `GPIO_RST`. With the default `GPIO_RST` of 1, only bit 0 is on.
- R2: When `lb_ads_n` is low at a clock edge while the block is idle, a cycle starts, and the strobes of the selected target are active from that edge onward.
- R3: A data phase keeps its strobes active for W+1 clocks, where W (0 to 15) is the value of `wait_cfg` sampled on the edge that opens the phase. `lb_ready` is high only during the last of those clocks. Peripheral and GPIO accesses use the same timing.
- R4: Address bit AW-1 selects the target: 0 selects the peripheral (`per_cs_n` low) and 1 selects the GPIO bank (`gpio_rd_en` or `gpio_wr_en`). Never more than one of `per_cs_n` low, `gpio_rd_en` and `gpio_wr_en` is active.
- R5: With `lb_wr` = 1 at the start, a peripheral cycle drives `per_wr_n` low. With `lb_wr` = 0 it drives `per_rd_n` low. Both are never low together.
- R6: On the edge that ends a read ready clock, `lb_rdata` captures `per_rdata` (peripheral) or `gpio_in` zero-extended (GPIO). It then holds that value until the next read capture.
- R7: On the edge that ends a GPIO write ready clock, `gpio_out` takes the low GW bits of the latched write word. At all other times it holds its value.
- R8: On the ready edge, if `lb_blast_n` is low, the block returns to idle and all strobes go inactive on the next clock. If it is high, a new data phase starts: `per_addr` increments by one modulo 2^(AW-1), `per_wdata` samples `lb_wdata`, and W is reloaded.
- R9: `lb_ads_n` low while a cycle is active has no effect on the address, the target or the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lb_ads_n | input | 1 | Active-low address strobe, starts a cycle |
| lb_blast_n | input | 1 | Active-low last-transfer flag, sampled on the ready edge |
| lb_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| lb_addr | input | AW | Word address; bit AW-1 selects the target |
| lb_wdata | input | DW | Write data from the bus master |
| wait_cfg | input | CW | Wait-state count W |
| lb_ready | output | 1 | Ready to the master, high on the last clock of a data phase |
| lb_rdata | output | DW | Captured read data |
| per_cs_n | output | 1 | Peripheral chip-select, active low |
| per_rd_n | output | 1 | Peripheral read strobe, active low |
| per_wr_n | output | 1 | Peripheral write strobe, active low |
| per_addr | output | AW-1 | Latched word address to the peripheral |
| per_wdata | output | DW | Latched write data to the peripheral |
| per_rdata | input | DW | Read data from the peripheral |
| gpio_in | input | GW | GPIO input buffer data |
| gpio_rd_en | output | 1 | GPIO input buffer enable |
| gpio_wr_en | output | 1 | GPIO output latch enable |
| gpio_out | output | GW | GPIO output latches |

## Verification
The bench builds the block with its defaults: AW=8, DW=16, GW=8 and CW=4. With GW narrower than DW, both the truncation of GPIO writes and the zero extension of GPIO reads are visible. The 4-bit count lets the bench drive both ends of the range, 0 and 15, as well as the typical value 14, and measure the resulting strobe lengths. The 7-bit word address is small enough that a burst starting at 0x7E wraps through 0x00 within three phases.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
    typedef enum logic { ST_IDLE = 1'b0, ST_ACT = 1'b1 } lbc_state_e;
    typedef enum logic { TGT_PER = 1'b0, TGT_GPIO = 1'b1 } lbc_tgt_e;
endpackage

// File: rtl/lbc_decode.sv
module lbc_decode
    import lbc_pkg::*;
#(
    parameter int AW      = 8,
    parameter int SEL_BIT = AW - 1
) (
    input  logic [AW-1:0] addr,
    output lbc_tgt_e      tgt
);
    always_comb begin
        tgt = addr[SEL_BIT] ? TGT_GPIO : TGT_PER;
    end
endmodule

// File: rtl/lbc_wait_cnt.sv
module lbc_wait_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          zero
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (dec)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R3: the controller never counts below zero
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !zero);
    // R3: a phase is either opened or counted, never both
    p_load_xor_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && dec));
endmodule

// File: rtl/lbc_cycle_ctrl.sv
module lbc_cycle_ctrl
    import lbc_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16,
    parameter int GW = 8,
    parameter int CW = 4,
    parameter logic [GW-1:0] GPIO_RST = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lb_ads_n,
    input  logic          lb_blast_n,
    input  logic          lb_wr,
    input  logic [AW-1:0] lb_addr,
    input  logic [DW-1:0] lb_wdata,
    input  logic [CW-1:0] wait_cfg,
    output logic          lb_ready,
    output logic [DW-1:0] lb_rdata,
    output logic          per_cs_n,
    output logic          per_rd_n,
    output logic          per_wr_n,
    output logic [AW-2:0] per_addr,
    output logic [DW-1:0] per_wdata,
    input  logic [DW-1:0] per_rdata,
    input  logic [GW-1:0] gpio_in,
    output logic          gpio_rd_en,
    output logic          gpio_wr_en,
    output logic [GW-1:0] gpio_out
);
    localparam int PAW = AW - 1;
    localparam logic [PAW-1:0] ADDR_STEP = 1;

    typedef struct packed {
        lbc_state_e     st;
        lbc_tgt_e       tgt;
        logic           wr;
        logic [PAW-1:0] addr;
        logic [DW-1:0]  wdata;
        logic [DW-1:0]  rdata;
        logic [GW-1:0]  gpio;
    } regs_t;

    regs_t         r_q, r_d;
    lbc_tgt_e      dec_tgt;
    logic          cnt_load, cnt_dec, cnt_zero;
    logic [DW-1:0] gpio_ext;

    lbc_decode #(.AW(AW), .SEL_BIT(AW - 1)) u_decode (
        .addr (lb_addr),
        .tgt  (dec_tgt)
    );

    lbc_wait_cnt #(.CW(CW)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (wait_cfg),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    always_comb begin
        gpio_ext          = '0;
        gpio_ext[GW-1:0]  = gpio_in;
    end

    always_comb begin
        r_d      = r_q;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (!lb_ads_n) begin
                    r_d.st    = ST_ACT;
                    r_d.tgt   = dec_tgt;
                    r_d.wr    = lb_wr;
                    r_d.addr  = lb_addr[PAW-1:0];
                    r_d.wdata = lb_wdata;
                    cnt_load  = 1'b1;
                end
            end
            ST_ACT: begin
                if (cnt_zero) begin
                    if (!r_q.wr)
                        r_d.rdata = (r_q.tgt == TGT_GPIO) ? gpio_ext : per_rdata;
                    else if (r_q.tgt == TGT_GPIO)
                        r_d.gpio = r_q.wdata[GW-1:0];
                    if (!lb_blast_n) begin
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.addr  = r_q.addr + ADDR_STEP;
                        r_d.wdata = lb_wdata;
                        cnt_load  = 1'b1;
                    end
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.tgt   <= TGT_PER;
            r_q.gpio  <= GPIO_RST;
        end else begin
            r_q <= r_d;
        end
    end

    logic act, act_per, act_gpio;
    assign act      = (r_q.st == ST_ACT);
    assign act_per  = act && (r_q.tgt == TGT_PER);
    assign act_gpio = act && (r_q.tgt == TGT_GPIO);

    assign lb_ready   = act && cnt_zero;
    assign lb_rdata   = r_q.rdata;
    assign per_cs_n   = !act_per;
    assign per_rd_n   = !(act_per && !r_q.wr);
    assign per_wr_n   = !(act_per && r_q.wr);
    assign per_addr   = r_q.addr;
    assign per_wdata  = r_q.wdata;
    assign gpio_rd_en = act_gpio && !r_q.wr;
    assign gpio_wr_en = act_gpio && r_q.wr;
    assign gpio_out   = r_q.gpio;

    logic any_strobe;
    assign any_strobe = !per_cs_n || gpio_rd_en || gpio_wr_en;

    p_one_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!per_cs_n, gpio_rd_en, gpio_wr_en}));
    p_rw_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!per_rd_n && !per_wr_n));
    p_ready_in_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lb_ready |-> any_strobe);
    p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !lb_ready |=> $stable(lb_rdata));
    p_gpio_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(lb_ready && gpio_wr_en) |=> $stable(gpio_out));
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_ready && !lb_blast_n) |=> (!any_strobe && !lb_ready));
    p_burst_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_ready && lb_blast_n) |=> (per_addr == $past(per_addr) + ADDR_STEP));
    p_hold_in_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (any_strobe && !lb_ready) |=> ($stable(per_addr) && $stable(per_cs_n)
                                       && $stable(gpio_rd_en) && $stable(gpio_wr_en)));
endmodule

// File: tb/lbc_cycle_ctrl_tb.sv
module lbc_cycle_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lb_ads_n = 1'b1, lb_blast_n = 1'b1, lb_wr = 1'b0;
    logic [7:0]  lb_addr = '0;
    logic [15:0] lb_wdata = '0;
    logic [3:0]  wait_cfg = '0;
    logic        lb_ready;
    logic [15:0] lb_rdata;
    logic        per_cs_n, per_rd_n, per_wr_n;
    logic [6:0]  per_addr;
    logic [15:0] per_wdata;
    logic [15:0] per_rdata = '0;
    logic [7:0]  gpio_in = '0;
    logic        gpio_rd_en, gpio_wr_en;
    logic [7:0]  gpio_out;

    int checks = 0, errors = 0, cyc = 0, act_len = 0;
    bit cmp_on = 0, done = 0;

    always #4 clk = ~clk;

    lbc_cycle_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .lb_ads_n(lb_ads_n), .lb_blast_n(lb_blast_n),
        .lb_wr(lb_wr), .lb_addr(lb_addr), .lb_wdata(lb_wdata), .wait_cfg(wait_cfg),
        .lb_ready(lb_ready), .lb_rdata(lb_rdata), .per_cs_n(per_cs_n),
        .per_rd_n(per_rd_n), .per_wr_n(per_wr_n), .per_addr(per_addr),
        .per_wdata(per_wdata), .per_rdata(per_rdata), .gpio_in(gpio_in),
        .gpio_rd_en(gpio_rd_en), .gpio_wr_en(gpio_wr_en), .gpio_out(gpio_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference model
    bit         m_act = 0, m_gp = 0, m_wr = 0;
    int         m_cnt = 0;
    logic [6:0] m_addr = '0;
    logic [15:0] m_wd = '0, m_rd = '0;
    logic [7:0] m_gpio = 8'h01;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_addr = '0; m_wd = '0; m_rd = '0; m_gpio = 8'h01; m_cnt = 0;
        end else if (!m_act) begin
            if (!lb_ads_n) begin
                m_act = 1; m_gp = lb_addr[7]; m_wr = lb_wr; m_addr = lb_addr[6:0];
                m_wd = lb_wdata; m_cnt = int'(wait_cfg);
            end
        end else if (m_cnt == 0) begin
            if (!m_wr) m_rd = m_gp ? {8'h00, gpio_in} : per_rdata;
            else if (m_gp) m_gpio = m_wd[7:0];
            if (!lb_blast_n) m_act = 0;
            else begin
                m_addr = m_addr + 7'd1; m_wd = lb_wdata; m_cnt = int'(wait_cfg);
            end
        end else begin
            m_cnt = m_cnt - 1;
        end
    end

    always @(negedge clk) begin
        cyc++;
        per_rdata <= 16'hA000 + 16'(cyc);
        gpio_in   <= 8'h3C ^ 8'(cyc);
        if (cmp_on) begin
            chk("R2 per_cs_n", 32'(per_cs_n), 32'(!(m_act && !m_gp)));
            chk("R5 per_rd_n", 32'(per_rd_n), 32'(!(m_act && !m_gp && !m_wr)));
            chk("R5 per_wr_n", 32'(per_wr_n), 32'(!(m_act && !m_gp && m_wr)));
            chk("R4 gpio_rd_en", 32'(gpio_rd_en), 32'(m_act && m_gp && !m_wr));
            chk("R4 gpio_wr_en", 32'(gpio_wr_en), 32'(m_act && m_gp && m_wr));
            chk("R3 lb_ready", 32'(lb_ready), 32'(m_act && m_cnt == 0));
            chk("R8 per_addr", 32'(per_addr), 32'(m_addr));
            chk("R8 per_wdata", 32'(per_wdata), 32'(m_wd));
            chk("R6 lb_rdata", 32'(lb_rdata), 32'(m_rd));
            chk("R7 gpio_out", 32'(gpio_out), 32'(m_gpio));
        end
    end

    // one access of nb data phases; inject > 0 pulses a stray strobe on that negedge
    task automatic access(input logic [7:0] a, input bit wr, input logic [15:0] wd,
                          input logic [3:0] w, input int nb, input int inject);
        int b = 0, n = 0;
        @(negedge clk);
        lb_ads_n = 0; lb_addr = a; lb_wr = wr; lb_wdata = wd; wait_cfg = w;
        lb_blast_n = (nb == 1) ? 1'b0 : 1'b1;
        act_len = 0;
        while (b < nb) begin
            @(negedge clk);
            n++;
            lb_ads_n = (n == inject) ? 1'b0 : 1'b1;
            if (n == inject) lb_addr = ~a;
            lb_blast_n = (b == nb - 1) ? 1'b0 : 1'b1;
            if (!per_cs_n || gpio_rd_en || gpio_wr_en) act_len++;
            if (n == inject + 1 && inject > 0)
                chk("R9 address kept after stray strobe", 32'(per_addr), 32'(a[6:0]));
            if (lb_ready) begin b++; lb_wdata = wd + 16'(b); end
        end
        @(negedge clk);
        lb_ads_n = 1; lb_blast_n = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 strobes idle in reset", 32'({per_cs_n, per_rd_n, per_wr_n, gpio_rd_en, gpio_wr_en, lb_ready}), 32'b111000);
        rst_n = 1;
        @(negedge clk);
        chk("R1 gpio_out one indicator on", 32'(gpio_out), 32'h01);
        chk("R1 lb_rdata cleared", 32'(lb_rdata), 32'h0);
        cmp_on = 1;

        access(8'h12, 0, 16'h0, 4'd14, 1, 0);
        chk("R3 strobe length W=14", act_len, 15);
        access(8'h05, 1, 16'hBEEF, 4'd0, 1, 0);
        chk("R3 strobe length W=0", act_len, 1);
        access(8'h83, 1, 16'h01A5, 4'd3, 1, 0);
        chk("R7 gpio_out truncated write", 32'(gpio_out), 32'hA5);
        access(8'h90, 0, 16'h0, 4'd15, 1, 0);
        chk("R3 GPIO strobe length W=15", act_len, 16);
        access(8'h7E, 0, 16'h0, 4'd2, 3, 0);
        chk("R8 burst wraps address", 32'(per_addr), 32'h00);
        chk("R8 burst length", act_len, 9);
        access(8'hC4, 1, 16'h0310, 4'd1, 2, 0);
        chk("R7 burst gpio last word", 32'(gpio_out), 32'h11);
        access(8'h21, 0, 16'h0, 4'd5, 1, 2);
        chk("R9 timing unchanged by stray strobe", act_len, 6);
        access(8'h40, 1, 16'h5555, 4'd4, 2, 0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule